// File: doc/BRIEF.md
# Translator Configuration Register Bank

This block is the software-visible face of an I/O address translator. It stores two 64-bit configuration words and presents both to the translator at all times. The first is a control word. The second is the physical base of the translation table. It also decodes a flush location, which has no side effect here, and answers accesses to every other offset in its window with zeros.

Software reaches each 64-bit word in one of two ways. A 64-bit access at the word's own offset covers the whole word. A 32-bit access covers one half. The halves are big-endian: the more significant half sits at the word's offset, and the less significant half sits four bytes above it.

Each access is a single-cycle request. Read data comes back one cycle after the request, qualified by a valid pulse. A request to an offset that the bank does not decode raises a one-cycle flag in that same response cycle.

Top module: `iommu_regbank`

## Requirements
- R1: While reset is held, and in the first cycle after it, both stored words read as zero on `ctrl_value` and `base_value`. `rsp_valid`, `rsp_rdata` and `unmapped_hit` are also zero, so the translator starts disabled.
- R2: A 64-bit write (`req_wide`=1) at offset 0x00 replaces the whole control word. A 64-bit write at offset 0x08 replaces the whole base word.
- R3: A 32-bit write (`req_wide`=0) at offset 0x00 or 0x08 puts `req_wdata[31:0]` into bits 63:32 of that word. Bits 31:0 of the word keep their value.
- R4: A write of either size at offset 0x04 or 0x0C puts `req_wdata[31:0]` into bits 31:0 of the control or base word. Bits 63:32 keep their value.
- R5: A 64-bit read at offset 0x00 or 0x08 returns the whole word on `rsp_rdata` one cycle after the request, with `rsp_valid` high for that one cycle.
- R6: A 32-bit read at offset 0x00 or 0x08 returns bits 63:32 of the word in `rsp_rdata[31:0]`. A read of either size at 0x04 or 0x0C returns bits 31:0 of the word there. In both cases `rsp_rdata[63:32]` is zero.
- R7: Offsets 0x10 and 0x14 are the flush location. Writes there change neither word. Reads there return zero. Neither raises `unmapped_hit`.
- R8: Any other offset counts as unmapped. This includes any offset that is not a multiple of four. A read there returns zero, a write there changes neither word, and `unmapped_hit` is high for exactly the cycle after the request.
- R9: `ctrl_value` and `base_value` show the stored words continuously. A write takes effect in the cycle after its request, and the words hold their value in any cycle after a cycle with no write.
- R10: In a cycle after one with no request, `rsp_valid` and `unmapped_hit` are low. A write never raises `rsp_valid`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Access request this cycle |
| req_write | input | 1 | 1 = write, 0 = read |
| req_wide | input | 1 | 1 = 64-bit access, 0 = 32-bit access |
| req_offset | input | OFFSET_W | Byte offset within the window |
| req_wdata | input | 64 | Write data; 32-bit writes use bits 31:0 |
| rsp_valid | output | 1 | Read data valid, one cycle after a read |
| rsp_rdata | output | 64 | Read data |
| unmapped_hit | output | 1 | One-cycle pulse after an access to an undecoded offset |
| ctrl_value | output | 64 | Current control word, for the translator |
| base_value | output | 64 | Current table base word, for the translator |

## Verification
The bench builds the bank with its default 5-bit offset, which is a 32-byte window. That width is small enough to visit every byte offset, decoded or not, with both access sizes. The write sweep therefore covers every half and whole-word merge, every flush write, and every unmapped or misaligned write. Each write is checked against an arithmetic model of both words. Full read sweeps run from several distinct register states, so every read path is compared in every position.

// File: rtl/iommu_regbank.sv
`timescale 1ns/1ps
module iommu_regbank #(
  parameter int OFFSET_W = 5,
  parameter int REG_W    = 64
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                req_valid,
  input  logic                req_write,
  input  logic                req_wide,
  input  logic [OFFSET_W-1:0] req_offset,
  input  logic [REG_W-1:0]    req_wdata,
  output logic                rsp_valid,
  output logic [REG_W-1:0]    rsp_rdata,
  output logic                unmapped_hit,
  output logic [REG_W-1:0]    ctrl_value,
  output logic [REG_W-1:0]    base_value
);
  localparam int NUM_REGS   = 2;
  localparam int HALF       = REG_W / 2;
  localparam int REG_BYTES  = REG_W / 8;
  localparam int HALF_BYTES = REG_BYTES / 2;
  localparam logic [OFFSET_W-1:0] FLUSH_HI = OFFSET_W'(NUM_REGS * REG_BYTES);
  localparam logic [OFFSET_W-1:0] FLUSH_LO = OFFSET_W'(NUM_REGS * REG_BYTES + HALF_BYTES);

  logic [REG_W-1:0] word_q  [NUM_REGS];
  logic [REG_W-1:0] rd_part [NUM_REGS];
  logic [NUM_REGS-1:0] hit_hi, hit_lo;
  logic hit_flush, decoded;
  logic is_wr, is_rd;
  logic [REG_W-1:0] rd_next;

  assign is_wr     = req_valid &  req_write;
  assign is_rd     = req_valid & ~req_write;
  assign hit_flush = (req_offset == FLUSH_HI) || (req_offset == FLUSH_LO);
  assign decoded   = hit_flush || (|hit_hi) || (|hit_lo);

  for (genvar k = 0; k < NUM_REGS; k++) begin : g_word
    localparam logic [OFFSET_W-1:0] HI_OFF = OFFSET_W'(k * REG_BYTES);
    localparam logic [OFFSET_W-1:0] LO_OFF = OFFSET_W'(k * REG_BYTES + HALF_BYTES);
    logic [REG_W-1:0] q;

    assign hit_hi[k] = (req_offset == HI_OFF);
    assign hit_lo[k] = (req_offset == LO_OFF);

    always_ff @(posedge clk) begin
      if (!rst_n) begin
        q <= '0;
      end else if (is_wr && hit_hi[k]) begin
        if (req_wide) q <= req_wdata;
        else          q[REG_W-1:HALF] <= req_wdata[HALF-1:0];
      end else if (is_wr && hit_lo[k]) begin
        q[HALF-1:0] <= req_wdata[HALF-1:0];
      end
    end

    assign word_q[k]  = q;
    assign rd_part[k] = hit_hi[k] ? (req_wide ? q : {{HALF{1'b0}}, q[REG_W-1:HALF]}) :
                        hit_lo[k] ? {{HALF{1'b0}}, q[HALF-1:0]} : '0;
  end

  always_comb begin
    rd_next = '0;
    for (int k = 0; k < NUM_REGS; k++) rd_next = rd_next | rd_part[k];
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rsp_valid    <= 1'b0;
      rsp_rdata    <= '0;
      unmapped_hit <= 1'b0;
    end else begin
      rsp_valid    <= is_rd;
      rsp_rdata    <= is_rd ? rd_next : '0;
      unmapped_hit <= req_valid & ~decoded;
    end
  end

  assign ctrl_value = word_q[0];
  assign base_value = word_q[1];
endmodule

// File: rtl/iommu_regbank_checks.sv
`timescale 1ns/1ps
module iommu_regbank_checks #(
  parameter int OFFSET_W = 5,
  parameter int REG_W    = 64
) (
  input logic                clk,
  input logic                rst_n,
  input logic                req_valid,
  input logic                req_write,
  input logic                req_wide,
  input logic [OFFSET_W-1:0] req_offset,
  input logic                rsp_valid,
  input logic [REG_W-1:0]    rsp_rdata,
  input logic                unmapped_hit,
  input logic [REG_W-1:0]    ctrl_value,
  input logic [REG_W-1:0]    base_value
);
  localparam int HALF = REG_W / 2;
  localparam logic [OFFSET_W-1:0] CTRL_HI = OFFSET_W'(0);
  localparam logic [OFFSET_W-1:0] CTRL_LO = OFFSET_W'(REG_W / 16);
  localparam logic [OFFSET_W-1:0] FL_HI   = OFFSET_W'(REG_W / 4);
  localparam logic [OFFSET_W-1:0] FL_LO   = OFFSET_W'(REG_W / 4 + REG_W / 16);

  assert_hold_without_write_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !(req_valid && req_write) |=> ($stable(ctrl_value) && $stable(base_value)));

  assert_flush_write_inert_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_write && (req_offset == FL_HI || req_offset == FL_LO))
    |=> ($stable(ctrl_value) && $stable(base_value) && !unmapped_hit));

  assert_upper_write_keeps_lower_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_write && !req_wide && req_offset == CTRL_HI)
    |=> $stable(ctrl_value[HALF-1:0]));

  assert_lower_write_keeps_upper_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_write && req_offset == CTRL_LO)
    |=> $stable(ctrl_value[REG_W-1:HALF]));

  assert_response_after_read_R5: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |-> $past(req_valid && !req_write));

  assert_narrow_read_upper_zero_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && $past(!req_wide)) |-> (rsp_rdata[REG_W-1:HALF] == '0));

  assert_unmapped_reads_zero_R8: assert property (@(posedge clk) disable iff (!rst_n)
    unmapped_hit |-> (rsp_rdata == '0 && $past(req_valid)));

  assert_idle_quiet_R10: assert property (@(posedge clk) disable iff (!rst_n)
    !req_valid |=> (!rsp_valid && !unmapped_hit));
endmodule

bind iommu_regbank iommu_regbank_checks #(.OFFSET_W(OFFSET_W), .REG_W(REG_W)) u_checks (
  .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_write(req_write),
  .req_wide(req_wide), .req_offset(req_offset), .rsp_valid(rsp_valid),
  .rsp_rdata(rsp_rdata), .unmapped_hit(unmapped_hit),
  .ctrl_value(ctrl_value), .base_value(base_value)
);

// File: tb/test_iommu_regbank.sv
`timescale 1ns/1ps
module test_iommu_regbank;
  localparam int OW = 5;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic req_valid = 1'b0, req_write = 1'b0, req_wide = 1'b0;
  logic [OW-1:0] req_offset = '0;
  logic [63:0] req_wdata = '0;
  logic rsp_valid, unmapped_hit;
  logic [63:0] rsp_rdata, ctrl_value, base_value;

  int checks = 0;
  int errors = 0;
  logic [63:0] m_ctrl = '0, m_base = '0;

  always #2.5 clk = ~clk;

  iommu_regbank #(.OFFSET_W(OW), .REG_W(64)) i_iommu_regbank (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_write(req_write),
    .req_wide(req_wide), .req_offset(req_offset), .req_wdata(req_wdata),
    .rsp_valid(rsp_valid), .rsp_rdata(rsp_rdata), .unmapped_hit(unmapped_hit),
    .ctrl_value(ctrl_value), .base_value(base_value)
  );

  task automatic check(input string req, input string what, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  function automatic bit is_decoded(input int off);
    return off == 0 || off == 4 || off == 8 || off == 12 || off == 16 || off == 20;
  endfunction

  function automatic logic [63:0] exp_read(input int off, input bit wide);
    case (off)
      0:  return wide ? m_ctrl : {32'h0, m_ctrl[63:32]};
      4:  return {32'h0, m_ctrl[31:0]};
      8:  return wide ? m_base : {32'h0, m_base[63:32]};
      12: return {32'h0, m_base[31:0]};
      default: return 64'h0;
    endcase
  endfunction

  task automatic model_write(input int off, input bit wide, input logic [63:0] d);
    case (off)
      0:  if (wide) m_ctrl = d; else m_ctrl[63:32] = d[31:0];
      4:  m_ctrl[31:0] = d[31:0];
      8:  if (wide) m_base = d; else m_base[63:32] = d[31:0];
      12: m_base[31:0] = d[31:0];
      default: ;
    endcase
  endtask

  // drive at negedge, response registered at the next posedge, sample at the following negedge
  task automatic access(input bit wr, input bit wide, input int off, input logic [63:0] d);
    req_valid = 1'b1; req_write = wr; req_wide = wide;
    req_offset = OW'(off); req_wdata = d;
    @(negedge clk);
    req_valid = 1'b0; req_write = 1'b0; req_wdata = '0;
  endtask

  task automatic read_sweep(input string tag);
    for (int off = 0; off < 32; off++) begin
      for (int w = 0; w < 2; w++) begin
        access(1'b0, w[0], off, 64'h0);
        check(off < 16 ? (w == 0 ? "R6" : (off % 8 == 0 ? "R5" : "R6")) : (is_decoded(off) ? "R7" : "R8"),
              $sformatf("%s read off=%0d wide=%0d data", tag, off, w), rsp_rdata, exp_read(off, w[0]));
        check("R5", $sformatf("%s read off=%0d rsp_valid", tag, off), {63'h0, rsp_valid}, 64'h1);
        check(is_decoded(off) ? "R7" : "R8", $sformatf("%s read off=%0d flag", tag, off),
              {63'h0, unmapped_hit}, {63'h0, !is_decoded(off)});
      end
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    $display("FAIL R10 watchdog actual=running expected=finished");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    check("R1", "ctrl in reset", ctrl_value, 64'h0);
    check("R1", "base in reset", base_value, 64'h0);
    check("R1", "rdata in reset", rsp_rdata, 64'h0);
    check("R1", "flags in reset", {62'h0, rsp_valid, unmapped_hit}, 64'h0);
    rst_n = 1'b1;
    @(negedge clk);
    check("R10", "idle flags", {62'h0, rsp_valid, unmapped_hit}, 64'h0);
    check("R1", "ctrl after reset", ctrl_value, 64'h0);
    read_sweep("reset");

    model_write(0, 1'b1, 64'hDEAD_BEEF_0BAD_F00D);
    access(1'b1, 1'b1, 0, 64'hDEAD_BEEF_0BAD_F00D);
    check("R2", "wide ctrl write", ctrl_value, m_ctrl);
    check("R10", "no rsp on write", {63'h0, rsp_valid}, 64'h0);
    model_write(8, 1'b1, 64'h1357_9BDF_2468_ACE0);
    access(1'b1, 1'b1, 8, 64'h1357_9BDF_2468_ACE0);
    check("R2", "wide base write", base_value, m_base);
    read_sweep("wide");

    for (int off = 0; off < 32; off++) begin
      for (int w = 0; w < 2; w++) begin
        logic [63:0] d;
        d = 64'h0123_4567_89AB_CDEF ^ (64'(off) * 64'h0101_0101_0101_0101)
            ^ (w == 1 ? 64'hFFFF_0000_FFFF_0000 : 64'h0);
        model_write(off, w[0], d);
        access(1'b1, w[0], off, d);
        check(off % 8 == 0 ? (w == 1 ? "R2" : "R3") : (off % 8 == 4 && off < 16 ? "R4" :
              (is_decoded(off) ? "R7" : "R8")),
              $sformatf("write off=%0d wide=%0d ctrl", off, w), ctrl_value, m_ctrl);
        check("R9", $sformatf("write off=%0d wide=%0d base", off, w), base_value, m_base);
        check(is_decoded(off) ? "R7" : "R8", $sformatf("write off=%0d flag", off),
              {63'h0, unmapped_hit}, {63'h0, !is_decoded(off)});
        check("R10", $sformatf("write off=%0d no rsp", off), {63'h0, rsp_valid}, 64'h0);
      end
    end
    @(negedge clk);
    check("R9", "ctrl held idle", ctrl_value, m_ctrl);
    check("R10", "idle after sweep", {62'h0, rsp_valid, unmapped_hit}, 64'h0);
    read_sweep("swept");

    model_write(4, 1'b0, 64'h0000_0000_FFFF_FFFF);
    access(1'b1, 1'b0, 4, 64'h0000_0000_FFFF_FFFF);
    model_write(8, 1'b0, 64'h0000_0000_8000_0001);
    access(1'b1, 1'b0, 8, 64'h0000_0000_8000_0001);
    check("R4", "narrow lower ctrl", ctrl_value, m_ctrl);
    check("R3", "narrow upper base", base_value, m_base);
    read_sweep("halves");

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule